// File: doc/BRIEF.md
# Two-Phase Constant Adder Datapath

This block adds a programmable constant to a stream of parallel input words. A controller with two states, capture and add, alternates on every clock. In the capture phase the input word passes through the left-operand multiplexer into the working accumulator. In the add phase the arithmetic unit adds the constant register to the accumulator, writes the sum back, and latches it onto the parallel output. Each operand therefore takes exactly two clocks, and the sum for the current operand is on the output right after the second clock.

The constant register resets to 2. It can be rewritten through a write-enable and data port. The parallel output is taken from the accumulator side of the datapath, never straight from the input pins. A ready flag, which is the inverse of the state bit, rises when the controller returns to capture and marks the output as valid.

Top module: `cadd_top`

## Requirements
- R1: While `rst` is high at a rising edge, the next cycle shows `ready` = 1 (capture phase) and `parOut` = 0.
- R2: After reset `ready` toggles on every rising edge: it is 0 after the first edge (add phase pending) and 1 after the second, and the pattern repeats.
- R3: On the rising edge where `ready` goes from 0 to 1, `parOut` becomes the word captured at the previous edge plus the constant register.
- R4: `parOut` does not change on the edge where `ready` falls, so the previous sum stays visible during the add phase.
- R5: `parIn` is sampled only on the edge where `ready` falls. A different value on `parIn` during the add phase does not affect the sum.
- R6: After reset the constant register holds 2, so input N yields N+2.
- R7: When `cfgWe` = 1 at a rising edge, the constant register takes `cfgData` at that edge. An add on that same edge still uses the old constant, and the new constant is used from the next add onward.
- R8: The sum wraps modulo 2^W (W = 8 by default), and no carry is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| parIn | input | W | Parallel operand word |
| cfgWe | input | 1 | Write enable for the constant register |
| cfgData | input | W | New constant value |
| parOut | output | W | Latched sum |
| ready | output | 1 | 1 in the capture phase: `parOut` holds a valid sum |

## Verification
Two things can land on the same edge: a write to the constant register and the add that reads that register. The bench raises `cfgWe` just before the add edge and expects the old constant in that sum and the new constant in the next pair. A separate case writes just before the capture edge and expects the new constant to be used at once. In every pair the bench also flips `parIn` during the add phase, so a datapath that resamples the input would produce a visibly wrong sum.

// File: rtl/cadd_pkg.sv
package cadd_pkg;

  typedef enum logic {
    PH_CAPTURE = 1'b0,
    PH_ADD     = 1'b1
  } phase_e;

  typedef enum logic {
    OP_PASS = 1'b0,
    OP_ADD  = 1'b1
  } aluOp_e;

  typedef struct packed {
    logic   selInput;   // left-operand mux: 1 = input word, 0 = accumulator
    aluOp_e aluOp;      // pass left operand or add the constant
    logic   latchOut;   // load the output register with the write-back word
  } strobe_t;

endpackage

// File: rtl/cadd_ctrl.sv
module cadd_ctrl
  import cadd_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  output strobe_t strobes,
  output logic    ready
);

  phase_e phase, phaseNext;

  always_comb begin
    phaseNext = (phase == PH_CAPTURE) ? PH_ADD : PH_CAPTURE;
  end

  always_ff @(posedge clk) begin
    if (rst) phase <= PH_CAPTURE;
    else     phase <= phaseNext;
  end

  always_comb begin
    strobes = '0;
    unique case (phase)
      PH_CAPTURE: begin
        strobes.selInput = 1'b1;
        strobes.aluOp    = OP_PASS;
        strobes.latchOut = 1'b0;
      end
      PH_ADD: begin
        strobes.selInput = 1'b0;
        strobes.aluOp    = OP_ADD;
        strobes.latchOut = 1'b1;
      end
      default: strobes = '0;
    endcase
  end

  assign ready = ~phase;

endmodule

// File: rtl/cadd_datapath.sv
module cadd_datapath
  import cadd_pkg::*;
#(
  parameter int unsigned W        = 8,
  parameter int unsigned K_RESET  = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  strobe_t      strobes,
  input  logic [W-1:0] parIn,
  input  logic         cfgWe,
  input  logic [W-1:0] cfgData,
  output logic [W-1:0] parOut,
  output logic [W-1:0] accView,
  output logic [W-1:0] constView
);

  localparam logic [W-1:0] K_INIT = W'(K_RESET);

  logic [W-1:0] acc0;
  logic [W-1:0] constReg;
  logic [W-1:0] accBranch;
  logic [W-1:0] leftOperand;
  logic [W-1:0] aluResult;
  logic [W-1:0] outLatch;

  // accumulator branch of the left-operand mux; output is fed from this side
  assign accBranch   = acc0;
  assign leftOperand = strobes.selInput ? parIn : accBranch;

  always_comb begin
    unique case (strobes.aluOp)
      OP_ADD:  aluResult = leftOperand + constReg;   // wraps modulo 2^W
      default: aluResult = leftOperand;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc0     <= '0;
      outLatch <= '0;
      constReg <= K_INIT;
    end else begin
      acc0 <= aluResult;
      if (strobes.latchOut) outLatch <= aluResult;
      if (cfgWe)            constReg <= cfgData;
    end
  end

  assign parOut    = outLatch;
  assign accView   = acc0;
  assign constView = constReg;

endmodule

// File: rtl/cadd_top.sv
module cadd_top
  import cadd_pkg::*;
#(
  parameter int unsigned W       = 8,
  parameter int unsigned K_RESET = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] parIn,
  input  logic         cfgWe,
  input  logic [W-1:0] cfgData,
  output logic [W-1:0] parOut,
  output logic         ready
);

  strobe_t      strobes;
  logic [W-1:0] accView;
  logic [W-1:0] constView;

  cadd_ctrl ctrl_i (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .ready   (ready)
  );

  cadd_datapath #(.W(W), .K_RESET(K_RESET)) dp_i (
    .clk       (clk),
    .rst       (rst),
    .strobes   (strobes),
    .parIn     (parIn),
    .cfgWe     (cfgWe),
    .cfgData   (cfgData),
    .parOut    (parOut),
    .accView   (accView),
    .constView (constView)
  );

endmodule

// File: rtl/cadd_chk.sv
module cadd_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] parIn,
  input logic         cfgWe,
  input logic [W-1:0] cfgData,
  input logic [W-1:0] parOut,
  input logic         ready,
  input logic [W-1:0] accVal,
  input logic [W-1:0] constVal
);

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (ready && parOut == '0)); // R1

  AST_READY_TOGGLE: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (ready != $past(ready))); // R2

  AST_SUM_RESULT: assert property (@(posedge clk) disable iff (rst)
    !ready |=> (parOut == W'($past(accVal) + $past(constVal)))); // R3

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    ready |=> $stable(parOut)); // R4

  AST_INPUT_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    ready |=> (accVal == $past(parIn))); // R5

  AST_CONST_WRITE: assert property (@(posedge clk) disable iff (rst)
    cfgWe |=> (constVal == $past(cfgData))); // R7

endmodule

bind cadd_top cadd_chk #(.W(W)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .parIn    (parIn),
  .cfgWe    (cfgWe),
  .cfgData  (cfgData),
  .parOut   (parOut),
  .ready    (ready),
  .accVal   (accView),
  .constVal (constView)
);

// File: tb/cadd_top_tb_top.sv
`timescale 1ns/1ps
module cadd_top_tb_top;

  localparam int unsigned W = 8;

  logic         clk = 1'b0;
  logic         rst;
  logic [W-1:0] parIn;
  logic         cfgWe;
  logic [W-1:0] cfgData;
  logic [W-1:0] parOut;
  logic         ready;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;   // 250 MHz

  cadd_top #(.W(W)) dut_i (
    .clk(clk), .rst(rst), .parIn(parIn), .cfgWe(cfgWe),
    .cfgData(cfgData), .parOut(parOut), .ready(ready)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One operand pair starting at a negedge in the capture phase.
  // wrEarly: constant write on the capture edge; wrLate: on the add edge.
  task automatic runPair(input logic [W-1:0] din, input logic [W-1:0] expSum,
                         input bit wrEarly, input bit wrLate,
                         input logic [W-1:0] wrVal, input string req);
    logic [W-1:0] prevOut;
    prevOut = parOut;
    parIn   = din;
    cfgWe   = wrEarly;
    cfgData = wrVal;
    @(negedge clk);
    check(ready == 1'b0, "R2 ready low after capture edge", int'(ready), 0);
    check(parOut == prevOut, "R4 output held on capture edge", int'(parOut), int'(prevOut));
    parIn   = ~din;        // R5: disturbance during add phase
    cfgWe   = wrLate;
    cfgData = wrVal;
    @(negedge clk);
    cfgWe = 1'b0;
    check(ready == 1'b1, "R2 ready high after add edge", int'(ready), 1);
    check(parOut == expSum, req, int'(parOut), int'(expSum));
  endtask

  task automatic testReset();
    rst = 1'b1; parIn = 8'hA5; cfgWe = 1'b0; cfgData = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(ready == 1'b1, "R1 ready after reset", int'(ready), 1);
    check(parOut == '0, "R1 output after reset", int'(parOut), 0);
  endtask

  task automatic testDefaultConst();
    for (int i = 0; i < 6; i++)
      runPair(W'(i * 37), W'(i * 37 + 2), 1'b0, 1'b0, '0, "R6 R3 default constant sum");
  endtask

  task automatic testWrap();
    runPair(8'hFF, 8'h01, 1'b0, 1'b0, '0, "R8 wrap FF+2");
    runPair(8'hFE, 8'h00, 1'b0, 1'b0, '0, "R8 wrap FE+2");
  endtask

  task automatic testInputIgnored();
    runPair(8'h10, 8'h12, 1'b0, 1'b0, '0, "R5 input change in add phase ignored");
  endtask

  task automatic testWriteEarly();
    runPair(8'h20, 8'h25, 1'b1, 1'b0, 8'h05, "R7 write on capture edge used at once");
    runPair(8'h30, 8'h35, 1'b0, 1'b0, '0, "R7 new constant kept");
  endtask

  task automatic testWriteAtAdd();
    runPair(8'h40, 8'h45, 1'b0, 1'b1, 8'h09, "R7 add edge uses old constant");
    runPair(8'h40, 8'h49, 1'b0, 1'b0, '0, "R7 next add uses new constant");
    runPair(8'hF8, 8'h01, 1'b0, 1'b0, '0, "R8 wrap with written constant");
  endtask

  task automatic testMidReset();
    parIn = 8'h77;
    @(negedge clk);                // now in add phase
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(ready == 1'b1, "R1 ready after mid-pair reset", int'(ready), 1);
    check(parOut == '0, "R1 output after mid-pair reset", int'(parOut), 0);
    runPair(8'h05, 8'h07, 1'b0, 1'b0, '0, "R1 R6 constant restored by reset");
  endtask

  initial begin
    testReset();
    testDefaultConst();
    testWrap();
    testInputIgnored();
    testWriteEarly();
    testWriteAtAdd();
    testMidReset();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule